// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns one nonmaskable request pin and a set of maskable request pins (eight by default) into interrupt requests for a processor core. Every pin first passes through a two-stage synchroniser. The block then compares the synchronised value with its value one cycle earlier to find edges. Each maskable line can be set to one of four sense modes, and has an enable bit and a status flag. The nonmaskable line has one polarity bit that picks the edge it responds to. No enable bit applies to it.

Software configures the block through a byte-wide register port: one write strobe, an address, write data, and combinational read data. The outputs are plain control pins with no handshake and no back-pressure. `nmi_req` is a one-cycle pulse. `irq_valid` and `irq_idx` are recomputed every cycle from the lines that are pending and enabled, so a consumer takes them whenever it wants. The request stays visible until software clears the status flag, or, for a level-sensed line, until the pin goes high again.

Register map (byte addresses): 0 = control (bit 0 = NMI polarity, where 1 means rising edge and 0 means falling edge); 1 = enable (bit i = line i); 2 = status (bit i = line i); 3 = sense for lines 0 to 3; 4 = sense for lines 4 to 7. In the sense registers, line i uses bits [2(i mod 4)+1 : 2(i mod 4)]. Every other address reads as zero. All registers reset to zero.

Top module: `eisc_top`

## Requirements
- R1: After reset every register reads 0, `nmi_req` and `irq_valid` are 0, and `irq_idx` is 0.
- R2: When the polarity bit is 0, a falling edge on `nmi_pin` gives exactly one cycle of `nmi_req`. When it is 1, a rising edge does the same. That cycle is the third rising clock edge after the pin changes, counting the two synchroniser stages. An edge in the other direction gives no pulse.
- R3: `nmi_req` does not depend on the enable register or on any maskable line's state.
- R4: A 2-bit sense field selects the mode: 00 = low level, 01 = falling edge, 10 = rising edge, 11 = both edges. In an edge mode, the matching edge sets the line's status bit at the third clock edge after the pin changes. The bit stays set until it is cleared.
- R5: In low-level mode the status bit shows the synchronised pin level inverted, and nothing is latched. When the pin returns high, the request disappears after two clock edges.
- R6: Status bits are set whatever the enable bit says. A line whose enable bit is 0 never drives `irq_valid` or `irq_idx`.
- R7: Writing the status register clears each bit written as 0 and leaves each bit written as 1 unchanged. If an edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `irq_valid` is high exactly when some line is both pending and enabled. `irq_idx` then gives the lowest such line index; otherwise it is 0.
- R9: The control, enable and sense registers read back the values written to them. Reading the status register returns the pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Nonmaskable request pin, asynchronous |
| irq_pin | input | N_LINES | Maskable request pins, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from the address |
| nmi_req | output | 1 | One-cycle nonmaskable request pulse |
| irq_valid | output | 1 | Some enabled line is pending |
| irq_idx | output | $clog2(N_LINES) | Lowest pending enabled line |

## Verification
The assertion on a single-cycle `nmi_req` assumes two things: software changes the polarity bit only while the nonmaskable pin is quiet, and pin levels are held long enough for the synchroniser to see them. The bench never writes the polarity bit during random pin activity, and it holds each pin value for at least one full clock. The priority and masking assertions place no condition on the inputs. The random phase therefore mixes status clears, sense rewrites and toggling pins freely, and a behavioural model checks every cycle.

// File: rtl/eisc_pkg.sv
package eisc_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_ENABLE = 1;
  localparam int unsigned ADDR_STATUS = 2;
  localparam int unsigned ADDR_SENSE0 = 3;
endpackage

// File: rtl/eisc_sync.sv
// Multi-stage synchroniser with a one-cycle history register for edge finding.
module eisc_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) chain[s] <= '1;
      hist <= '1;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
      hist <= chain[STAGES-1];
    end
  end

  assign sync_o = chain[STAGES-1];
  assign prev_o = hist;
endmodule

// File: rtl/eisc_line.sv
// Per-line sense logic: edge flag in edge modes, live level in low mode.
module eisc_line
  import eisc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  input  logic   prev_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   hit_o,
  output logic   flag_o,
  output logic   pend_o
);
  logic flag_q;

  always_comb begin
    unique case (mode_i)
      SENSE_FALL: hit_o = prev_i & ~sync_i;
      SENSE_RISE: hit_o = ~prev_i & sync_i;
      SENSE_BOTH: hit_o = prev_i ^ sync_i;
      default:    hit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (mode_i == SENSE_LOW) flag_q <= 1'b0;
    else                          flag_q <= hit_o | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign pend_o = (mode_i == SENSE_LOW) ? ~sync_i : flag_q;
endmodule

// File: rtl/eisc_regs.sv
// Register file: polarity, enable, sense fields, read mux, status clear vector.
module eisc_regs
  import eisc_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  pend_i,
  output logic [N-1:0]  en_o,
  output sense_e        mode_o [N],
  output logic          pol_o,
  output logic [N-1:0]  clr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned SBITS = 2 * N;

  logic [N-1:0]     en_q;
  logic [SBITS-1:0] sense_q;
  logic             pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sense_q <= '0;
      pol_q   <= 1'b0;
    end else if (wr_en) begin
      if (addr == AW'(ADDR_CTRL))   pol_q <= wdata[0];
      if (addr == AW'(ADDR_ENABLE)) en_q  <= wdata[N-1:0];
      for (int k = 0; k < int'(SBITS); k++) begin
        if (addr == AW'(ADDR_SENSE0 + k / DW)) sense_q[k] <= wdata[k % DW];
      end
    end
  end

  for (genvar i = 0; i < int'(N); i++) begin : g_mode
    assign mode_o[i] = sense_e'(sense_q[2*i +: 2]);
  end

  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign clr_o = (wr_en && addr == AW'(ADDR_STATUS)) ? ~wdata[N-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr == AW'(ADDR_CTRL))        rdata_o[0]     = pol_q;
    else if (addr == AW'(ADDR_ENABLE)) rdata_o[N-1:0] = en_q;
    else if (addr == AW'(ADDR_STATUS)) rdata_o[N-1:0] = pend_i;
    else begin
      for (int k = 0; k < int'(SBITS); k++) begin
        if (addr == AW'(ADDR_SENSE0 + k / DW)) rdata_o[k % DW] = sense_q[k];
      end
    end
  end
endmodule

// File: rtl/eisc_prio.sv
// Fixed-priority selector: lowest set index wins.
module eisc_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/eisc_top.sv
module eisc_top
  import eisc_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_pin,
  input  logic [N_LINES-1:0] irq_pin,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               nmi_req,
  output logic               irq_valid,
  output logic [IDX_W-1:0]   irq_idx
);
  localparam int unsigned W = N_LINES + 1;

  logic [W-1:0]       sync_all, prev_all;
  logic [N_LINES-1:0] en_q, clr_vec, hit_vec, flag_vec, pend_vec;
  sense_e             mode_vec [N_LINES];
  logic               pol_q;

  eisc_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    ({nmi_pin, irq_pin}),
    .sync_o (sync_all),
    .prev_o (prev_all)
  );

  eisc_regs #(.N(N_LINES), .AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .pend_i  (pend_vec),
    .en_o    (en_q),
    .mode_o  (mode_vec),
    .pol_o   (pol_q),
    .clr_o   (clr_vec),
    .rdata_o (bus_rdata)
  );

  for (genvar i = 0; i < int'(N_LINES); i++) begin : g_line
    eisc_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_all[i]),
      .prev_i (prev_all[i]),
      .mode_i (mode_vec[i]),
      .clr_i  (clr_vec[i]),
      .hit_o  (hit_vec[i]),
      .flag_o (flag_vec[i]),
      .pend_o (pend_vec[i])
    );
  end

  eisc_prio #(.N(N_LINES), .IW(IDX_W)) u_prio (
    .req_i   (pend_vec & en_q),
    .valid_o (irq_valid),
    .idx_o   (irq_idx)
  );

  // Nonmaskable path: no enable term anywhere on it.
  assign nmi_req = pol_q ? (~prev_all[N_LINES] & sync_all[N_LINES])
                         : (prev_all[N_LINES] & ~sync_all[N_LINES]);
endmodule

// File: rtl/eisc_check.sv
module eisc_check #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nmi_req,
  input logic          irq_valid,
  input logic [IW-1:0] irq_idx,
  input logic [N-1:0]  en,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  hit,
  input logic [N-1:0]  flag,
  input logic          nmi_sync,
  input logic          pol
);
  logic [N-1:0] live;
  assign live = pend & en;

  // R2: a request is a single-cycle pulse
  a_r2_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  // R3: the pulse follows the pin level selected by polarity, with no mask term
  a_r3_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (nmi_sync == pol));

  // R6: masked lines never produce a request
  a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> !irq_valid);

  // R7: a detected edge leaves its flag set even under a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (($past(hit) & ~flag) == '0));

  // R8: the chosen line is live and no lower live line exists
  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (live[irq_idx] && ((live & ((N'(1) << irq_idx) - N'(1))) == '0)));
endmodule

bind eisc_top eisc_check #(.N(N_LINES), .IW(IDX_W)) u_check (
  .clk       (clk),
  .rst_n     (rst_n),
  .nmi_req   (nmi_req),
  .irq_valid (irq_valid),
  .irq_idx   (irq_idx),
  .en        (en_q),
  .pend      (pend_vec),
  .hit       (hit_vec),
  .flag      (flag_vec),
  .nmi_sync  (sync_all[N_LINES]),
  .pol       (pol_q)
);

// File: tb/eisc_top_bench.sv
module eisc_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi_pin = 1'b1;
  logic [7:0] irq_pin = 8'hFF;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd2;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       nmi_req, irq_valid;
  logic [2:0] irq_idx;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit chk_on = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  eisc_top u_eisc_top (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .nmi_req(nmi_req), .irq_valid(irq_valid),
    .irq_idx(irq_idx)
  );

  // Behavioural reference model
  logic [8:0]  m_s1 = '1, m_s2 = '1, m_pv = '1;
  logic [7:0]  m_en = '0, m_flag = '0;
  logic [15:0] m_sense = '0;
  logic        m_pol = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_pv = '1;
      m_en = '0; m_flag = '0; m_sense = '0; m_pol = 1'b0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        int md;
        bit fell, rose, h, c;
        md   = int'(m_sense[2*i +: 2]);
        fell = m_pv[i] && !m_s2[i];
        rose = !m_pv[i] && m_s2[i];
        h    = (md == 1 && fell) || (md == 2 && rose) || (md == 3 && (fell || rose));
        c    = bus_wr && bus_addr == 3'd2 && !bus_wdata[i];
        if (md == 0) m_flag[i] = 1'b0;
        else         m_flag[i] = h || (m_flag[i] && !c);
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_pol = bus_wdata[0];
          3'd1: m_en = bus_wdata;
          3'd3: m_sense[7:0] = bus_wdata;
          3'd4: m_sense[15:8] = bus_wdata;
          default: ;
        endcase
      end
      m_pv = m_s2; m_s2 = m_s1; m_s1 = {nmi_pin, irq_pin};
    end
  end

  function automatic logic [7:0] m_pend();
    logic [7:0] p;
    for (int i = 0; i < 8; i++)
      p[i] = (m_sense[2*i +: 2] == 2'b00) ? !m_s2[i] : m_flag[i];
    return p;
  endfunction

  function automatic logic m_nmi();
    return m_pol ? (!m_pv[8] && m_s2[8]) : (m_pv[8] && !m_s2[8]);
  endfunction

  function automatic logic [2:0] m_idx();
    logic [7:0] l;
    l = m_pend() & m_en;
    for (int i = 0; i < 8; i++) if (l[i]) return 3'(i);
    return 3'd0;
  endfunction

  function automatic logic [7:0] m_rd();
    case (bus_addr)
      3'd0: return {7'd0, m_pol};
      3'd1: return m_en;
      3'd2: return m_pend();
      3'd3: return m_sense[7:0];
      3'd4: return m_sense[15:8];
      default: return 8'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      logic [19:0] act, exp;
      act = {nmi_req, irq_valid, irq_idx, bus_rdata, 7'd0};
      exp = {m_nmi(), |(m_pend() & m_en), m_idx(), m_rd(), 7'd0};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s model: actual nmi=%b v=%b idx=%0d rd=%h expected nmi=%b v=%b idx=%0d rd=%h",
                 cur_req, act[19], act[18], act[17:15], act[14:7],
                 exp[19], exp[18], exp[17:15], exp[14:7]);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_addr = 3'd2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
    bus_addr = a; #0.5;
    chk(req, 32'(bus_rdata), 32'(exp));
    bus_addr = 3'd2;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int pulses;
    tick(5);
    rst_n = 1'b1;
    chk_on = 1'b1;
    tick();
    // R1 reset values
    cur_req = "R1";
    rd_chk("R1", 3'd0, 8'h00);
    rd_chk("R1", 3'd1, 8'h00);
    rd_chk("R1", 3'd3, 8'h00);
    rd_chk("R1", 3'd4, 8'h00);
    chk("R1", {nmi_req, irq_valid, irq_idx}, 5'b0);

    // R9 register readback
    cur_req = "R9";
    wr(3'd1, 8'hFF);
    wr(3'd3, 8'hA5);   // lines 0,1 falling; lines 2,3 rising
    wr(3'd4, 8'h0F);   // lines 4,5 both edges; lines 6,7 low level
    rd_chk("R9", 3'd1, 8'hFF);
    rd_chk("R9", 3'd3, 8'hA5);
    rd_chk("R9", 3'd4, 8'h0F);
    rd_chk("R9", 3'd6, 8'h00);

    // R2 falling polarity: single pulse at the third edge
    cur_req = "R2";
    nmi_pin = 1'b0;
    tick(2);
    chk("R2", 32'(nmi_req), 32'd1);
    tick();
    chk("R2", 32'(nmi_req), 32'd0);
    nmi_pin = 1'b1;
    pulses = 0;
    repeat (6) begin tick(); pulses += int'(nmi_req); end
    chk("R2", 32'(pulses), 32'd0);
    wr(3'd0, 8'h01);
    nmi_pin = 1'b0; tick(4);
    nmi_pin = 1'b1;
    pulses = 0;
    repeat (6) begin tick(); pulses += int'(nmi_req); end
    chk("R2", 32'(pulses), 32'd1);

    // R3 nmi unaffected by masks
    cur_req = "R3";
    wr(3'd1, 8'h00);
    nmi_pin = 1'b0; tick(4);
    nmi_pin = 1'b1;
    pulses = 0;
    repeat (6) begin tick(); pulses += int'(nmi_req); end
    chk("R3", 32'(pulses), 32'd1);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFF);

    // R4 edge modes
    cur_req = "R4";
    irq_pin = 8'b1100_0000;   // falls on 0..5, lines 6/7 stay high
    tick(3);
    rd_chk("R4", 3'd2, 8'b0011_0011);  // falling (0,1) and both (4,5)
    irq_pin = 8'hFF;
    tick(3);
    rd_chk("R4", 3'd2, 8'b0011_1111);  // rising (2,3) now set too
    chk("R4", {irq_valid, irq_idx}, {1'b1, 3'd0});

    // R7 clear semantics
    cur_req = "R7";
    wr(3'd2, 8'b1111_1110);
    rd_chk("R7", 3'd2, 8'b0011_1110);
    chk("R8", {irq_valid, irq_idx}, {1'b1, 3'd1});
    // set wins: line 1 edge lands in the cycle of its clear
    irq_pin[1] = 1'b0;
    tick(2);
    wr(3'd2, 8'h00);
    rd_chk("R7", 3'd2, 8'b0000_0010);
    wr(3'd2, 8'h00);
    irq_pin[1] = 1'b1;
    tick(3);
    rd_chk("R7", 3'd2, 8'h00);

    // R5 level mode
    cur_req = "R5";
    irq_pin[6] = 1'b0;
    tick(2);
    rd_chk("R5", 3'd2, 8'b0100_0000);
    chk("R5", {irq_valid, irq_idx}, {1'b1, 3'd6});
    wr(3'd2, 8'h00);
    rd_chk("R5", 3'd2, 8'b0100_0000);
    irq_pin[6] = 1'b1;
    tick(2);
    rd_chk("R5", 3'd2, 8'h00);
    chk("R5", 32'(irq_valid), 32'd0);

    // R6 masking
    cur_req = "R6";
    wr(3'd1, 8'h00);
    irq_pin[0] = 1'b0;
    tick(3);
    rd_chk("R6", 3'd2, 8'h01);
    chk("R6", 32'(irq_valid), 32'd0);
    irq_pin[0] = 1'b1;

    // R8 priority with several lines pending
    cur_req = "R8";
    wr(3'd1, 8'b0011_0100);
    irq_pin = 8'b1100_0000; tick(2); irq_pin = 8'hFF; tick(3);
    chk("R8", {irq_valid, irq_idx}, {1'b1, 3'd2});
    wr(3'd2, 8'b1111_1011);
    chk("R8", {irq_valid, irq_idx}, {1'b1, 3'd4});

    // Random traffic, polarity untouched
    cur_req = "R8";
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if ((n % 2) == 0) begin
        nmi_pin = 1'($urandom);
        irq_pin = 8'($urandom);
      end
      if (r == 0)      wr(3'd2, 8'($urandom));
      else if (r == 1) wr(3'd1, 8'($urandom));
      else if (r == 2) wr(3'($urandom_range(3, 4)), 8'($urandom));
      else begin
        bus_addr = 3'($urandom_range(0, 7));
        tick();
      end
    end
    bus_addr = 3'd2;
    tick(2);
    chk_on = 1'b0;
    finish_run();
  end
endmodule